// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block is the control-flow helper of an 8-bit processor with a 16-bit address space. The core hands it one stack or flow operation at a time: saving or restoring the accumulator, saving or restoring the status byte, a subroutine call and its return, a software break, a return from an interrupt, or a direct write of the stack pointer. The block owns the 8-bit stack pointer, drives a byte-wide memory port with separate read and write strobes, and hands new values for the program counter, the accumulator and the status byte back to the core through load strobes. After reset it fetches the start address from the reset vector on its own.

The stack lives in one fixed 256-byte page and grows toward lower addresses. The core starts an operation with a one-cycle `start` pulse and a 4-bit `op` code, and the block answers with a one-cycle `done` pulse. The load strobes and their values are valid only in the `done` cycle. Memory reads are combinational: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_rd` is high.

Each operation runs as a fixed walk through named states. `IDLE` waits for `start`. `WR_ONE` and `RD_ONE` move one byte. `WR_HI`, `WR_LO` and `WR_ST` store the high byte of the return address, then its low byte, then the status byte. `RD_ST`, `RD_LO` and `RD_HI` fetch the status byte, then the low address byte, then the high address byte. `VEC_LO` and `VEC_HI` read a two-byte vector. `FIN` raises `done` and drives the load strobes, and always returns to `IDLE`. Only these transitions exist:
- `IDLE` → `WR_ONE` (push accumulator, push status)
- `IDLE` → `RD_ONE` (pull accumulator, pull status)
- `IDLE` → `WR_HI` (call, break)
- `IDLE` → `RD_LO` (return)
- `IDLE` → `RD_ST` (return from interrupt)
- `IDLE` → `FIN` (stack pointer write, undefined codes)
- `WR_ONE` → `FIN` and `RD_ONE` → `FIN`
- `WR_HI` → `WR_LO`
- `WR_LO` → `WR_ST` (break) or `FIN` (call)
- `WR_ST` → `VEC_LO`
- `RD_ST` → `RD_LO`, `RD_LO` → `RD_HI`, `RD_HI` → `FIN`
- `VEC_LO` → `VEC_HI` → `FIN`
- `FIN` → `IDLE`
- Reset leaves the machine in `VEC_LO`, fetching the reset vector.

Top module: `stk_seq`

## Requirements
- R1: Operation codes on `op` are 0 push accumulator, 1 push status, 2 pull accumulator, 3 pull status, 4 call, 5 return, 6 return from interrupt, 7 break, 8 stack pointer write. Codes 9 to 15 finish with no memory access and no load. A `start` that arrives while `busy` is high is ignored.
- R2: When reset is released, the block reads the low byte at RESET_VEC and the high byte at RESET_VEC+1. It then pulses `done` with `pc_load` high and `pc_out` holding that word. While reset is held, `sp_out` equals SP_INIT and `done` and `mem_wr` are low.
- R3: A single-byte push writes to address {STACK_PAGE, SP} and then decrements SP by one.
- R4: A single-byte pull first increments SP by one and then reads address {STACK_PAGE, new SP}.
- R5: A status push stores `status_in` with bits 4 and 5 forced to one. The same forced byte is what a break stores.
- R6: A call stores `pc_in`-1 on the stack, high byte first, then the low byte. It then loads `pc_out` with `target_in`.
- R7: A return pulls the low byte first, then the high byte, and loads `pc_out` with that word plus one.
- R8: A break stores `pc_in`+1 (high byte, then low byte) and then the forced status byte. It reads the vector at BREAK_VEC (low byte) and BREAK_VEC+1 (high byte) into `pc_out`, and loads status with bit 2 (interrupt disable) set and all other bits taken from `status_in`.
- R9: A return from interrupt pulls the status byte and loads it unchanged. It then pulls the low byte and the high byte of the program counter and loads that word with no adjustment.
- R10: A pull into the accumulator loads `acc_out` with the byte read. It also loads status with bit 7 (N) equal to bit 7 of that byte and bit 1 (Z) set exactly when the byte is zero, and passes every other bit of `status_in` through. A status pull loads the byte as read.
- R11: A stack pointer write copies `sp_in` into SP and raises neither `status_load`, `acc_load` nor `pc_load`.
- R12: SP wraps modulo 256. A push at SP=0x00 leaves SP=0xFF, a pull at SP=0xFF reads offset 0x00, and no stack access leaves STACK_PAGE.
- R13: Each cycle performs at most one memory access. Accesses run in consecutive cycles starting in the cycle after `start` is taken, and `done` is high for exactly the one cycle after the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the operation on `op` |
| op | input | 4 | Operation code (R1) |
| pc_in | input | 16 | Address of the next instruction |
| target_in | input | 16 | Call destination |
| acc_in | input | 8 | Accumulator value to push |
| status_in | input | 8 | Current status byte |
| sp_in | input | 8 | New stack pointer for a stack pointer write |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | New program counter |
| acc_load | output | 1 | Load `acc_out` into the accumulator |
| acc_out | output | 8 | New accumulator value |
| status_load | output | 1 | Load `status_out` into the status byte |
| status_out | output | 8 | New status byte |
| sp_out | output | 8 | Current stack pointer |

## Verification
The bench keeps STACK_PAGE at 0x01 and both vector addresses at their defaults. It sets SP_INIT to 0x01, so that right after reset two pushes take the pointer through zero to 0xFF and a pull at 0xFF reads offset zero. That puts the wrap at both ends of the page under test without hundreds of filler pushes. Calls, breaks and returns then run near the middle of the page, where the order of the stored bytes and the one-off adjustments of the return address can be read straight from the stack image.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [3:0] {
        OP_PUSH_A = 4'd0,
        OP_PUSH_P = 4'd1,
        OP_PULL_A = 4'd2,
        OP_PULL_P = 4'd3,
        OP_CALL   = 4'd4,
        OP_RET    = 4'd5,
        OP_RTI    = 4'd6,
        OP_BRK    = 4'd7,
        OP_SETSP  = 4'd8,
        OP_NONE   = 4'd14,
        OP_BOOT   = 4'd15
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_ONE,
        S_RD_ONE,
        S_WR_HI,
        S_WR_LO,
        S_WR_ST,
        S_RD_ST,
        S_RD_LO,
        S_RD_HI,
        S_VEC_LO,
        S_VEC_HI,
        S_FIN
    } state_e;

    localparam int FLAG_N = 7;
    localparam int FLAG_Z = 1;
    localparam int FLAG_I = 2;
    localparam logic [7:0] PUSH_FORCE = 8'h30;

    function automatic op_e decode_op(input logic [3:0] raw);
        if (raw <= 4'd8) begin
            return op_e'(raw);
        end
        return OP_NONE;
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int         DW      = 8,
    parameter logic [7:0] SP_INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_up
);

    localparam logic [DW-1:0] ONE = DW'(1);

    assign sp_up = sp + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= SP_INIT[DW-1:0];
        end else if (load) begin
            sp <= load_val;
        end else if (inc) begin
            sp <= sp_up;
        end else if (dec) begin
            sp <= sp - ONE;
        end
    end

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !inc) |=> (sp == $past(sp) - ONE));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (sp == $past(sp) + ONE));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] op_raw,
    output state_e     state,
    output op_e        op_q,
    output op_e        op_dec,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       stack_acc,
    output logic       sp_inc,
    output logic       sp_dec,
    output logic       sp_load
);

    state_e state_n;

    assign op_dec = decode_op(op_raw);
    assign accept = (state == S_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_VEC_LO;
            op_q  <= OP_BOOT;
        end else begin
            state <= state_n;
            if (accept) begin
                op_q <= op_dec;
            end
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    unique case (op_dec)
                        OP_PUSH_A, OP_PUSH_P: state_n = S_WR_ONE;
                        OP_PULL_A, OP_PULL_P: state_n = S_RD_ONE;
                        OP_CALL, OP_BRK:      state_n = S_WR_HI;
                        OP_RET:               state_n = S_RD_LO;
                        OP_RTI:               state_n = S_RD_ST;
                        default:              state_n = S_FIN;
                    endcase
                end
            end
            S_WR_ONE: state_n = S_FIN;
            S_RD_ONE: state_n = S_FIN;
            S_WR_HI:  state_n = S_WR_LO;
            S_WR_LO:  state_n = (op_q == OP_BRK) ? S_WR_ST : S_FIN;
            S_WR_ST:  state_n = S_VEC_LO;
            S_RD_ST:  state_n = S_RD_LO;
            S_RD_LO:  state_n = S_RD_HI;
            S_RD_HI:  state_n = S_FIN;
            S_VEC_LO: state_n = S_VEC_HI;
            S_VEC_HI: state_n = S_FIN;
            S_FIN:    state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state != S_IDLE);
        done      = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        stack_acc = 1'b0;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        sp_load   = accept && (op_dec == OP_SETSP);
        unique case (state)
            S_WR_ONE, S_WR_HI, S_WR_LO, S_WR_ST: begin
                mem_wr    = 1'b1;
                stack_acc = 1'b1;
                sp_dec    = 1'b1;
            end
            S_RD_ONE, S_RD_ST, S_RD_LO, S_RD_HI: begin
                mem_rd    = 1'b1;
                stack_acc = 1'b1;
                sp_inc    = 1'b1;
            end
            S_VEC_LO, S_VEC_HI: mem_rd = 1'b1;
            S_FIN:              done   = 1'b1;
            default: ;
        endcase
    end

    // R13
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (op_q == $past(op_q)));

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
    import stk_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] RESET_VEC  = 16'hFFFC,
    parameter logic [15:0] BREAK_VEC  = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  state_e        state,
    input  op_e           op_q,
    input  op_e           op_dec,
    input  logic          accept,
    input  logic          stack_acc,
    input  logic          mem_wr,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] target_in,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] sp_up,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic          acc_load,
    output logic [DW-1:0] acc_out,
    output logic          status_load,
    output logic [DW-1:0] status_out
);

    localparam logic [AW-1:0] ONE_W = AW'(1);
    localparam int            HB    = AW - DW;

    logic [AW-1:0] word_q;
    logic [AW-1:0] tgt_q;
    logic [DW-1:0] byte_q;
    logic [DW-1:0] st_q;
    logic [AW-1:0] vec_base;

    assign vec_base = (op_q == OP_BOOT) ? RESET_VEC : BREAK_VEC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            tgt_q  <= '0;
            byte_q <= '0;
            st_q   <= '0;
        end else if (accept) begin
            word_q <= (op_dec == OP_CALL) ? (pc_in - ONE_W) : (pc_in + ONE_W);
            tgt_q  <= target_in;
            byte_q <= (op_dec == OP_PUSH_A) ? acc_in : (status_in | PUSH_FORCE);
            st_q   <= status_in;
        end else begin
            unique case (state)
                S_RD_ONE:           byte_q               <= mem_rdata;
                S_RD_ST:            st_q                 <= mem_rdata;
                S_RD_LO, S_VEC_LO:  word_q[DW-1:0]       <= mem_rdata;
                S_RD_HI, S_VEC_HI:  word_q[AW-1:AW-HB]   <= mem_rdata[HB-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_WR_ONE: begin
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = byte_q;
            end
            S_WR_HI: begin
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = word_q[AW-1:AW-DW];
            end
            S_WR_LO: begin
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = word_q[DW-1:0];
            end
            S_WR_ST: begin
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = st_q | PUSH_FORCE;
            end
            S_RD_ONE, S_RD_ST, S_RD_LO, S_RD_HI: mem_addr = {STACK_PAGE, sp_up};
            S_VEC_LO: mem_addr = vec_base;
            S_VEC_HI: mem_addr = vec_base + ONE_W;
            default: ;
        endcase
    end

    always_comb begin
        pc_load     = 1'b0;
        pc_out      = word_q;
        acc_load    = 1'b0;
        acc_out     = byte_q;
        status_load = 1'b0;
        status_out  = st_q;
        if (state == S_FIN) begin
            unique case (op_q)
                OP_BOOT, OP_RTI: begin
                    pc_load = 1'b1;
                    status_load = (op_q == OP_RTI);
                end
                OP_CALL: begin
                    pc_load = 1'b1;
                    pc_out  = tgt_q;
                end
                OP_RET: begin
                    pc_load = 1'b1;
                    pc_out  = word_q + ONE_W;
                end
                OP_BRK: begin
                    pc_load     = 1'b1;
                    status_load = 1'b1;
                    status_out[FLAG_I] = 1'b1;
                end
                OP_PULL_A: begin
                    acc_load    = 1'b1;
                    status_load = 1'b1;
                    status_out[FLAG_N] = byte_q[DW-1];
                    status_out[FLAG_Z] = (byte_q == '0);
                end
                OP_PULL_P: begin
                    status_load = 1'b1;
                    status_out  = byte_q;
                end
                default: ;
            endcase
        end
    end

    // R12
    page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_acc |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    // R5
    forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && (state == S_WR_ST || (state == S_WR_ONE && op_q == OP_PUSH_P)))
            |-> (mem_wdata[5:4] == 2'b11));

    // R10
    pull_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load |-> (status_load && status_out[FLAG_Z] == (acc_out == '0)
                      && status_out[FLAG_N] == acc_out[DW-1]));

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  SP_INIT    = 8'hFF,
    parameter logic [15:0] RESET_VEC  = 16'hFFFC,
    parameter logic [15:0] BREAK_VEC  = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] target_in,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          busy,
    output logic          done,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic          acc_load,
    output logic [DW-1:0] acc_out,
    output logic          status_load,
    output logic [DW-1:0] status_out,
    output logic [DW-1:0] sp_out
);

    state_e        state;
    op_e           op_q;
    op_e           op_dec;
    logic          accept;
    logic          stack_acc;
    logic          sp_inc;
    logic          sp_dec;
    logic          sp_load;
    logic [DW-1:0] sp_up;

    stk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_raw    (op),
        .state     (state),
        .op_q      (op_q),
        .op_dec    (op_dec),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .stack_acc (stack_acc),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .sp_load   (sp_load)
    );

    stk_ptr #(
        .DW      (DW),
        .SP_INIT (SP_INIT)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .load     (sp_load),
        .load_val (sp_in),
        .sp       (sp_out),
        .sp_up    (sp_up)
    );

    stk_dpath #(
        .AW         (AW),
        .DW         (DW),
        .STACK_PAGE (STACK_PAGE),
        .RESET_VEC  (RESET_VEC),
        .BREAK_VEC  (BREAK_VEC)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .op_q        (op_q),
        .op_dec      (op_dec),
        .accept      (accept),
        .stack_acc   (stack_acc),
        .mem_wr      (mem_wr),
        .pc_in       (pc_in),
        .target_in   (target_in),
        .acc_in      (acc_in),
        .status_in   (status_in),
        .mem_rdata   (mem_rdata),
        .sp          (sp_out),
        .sp_up       (sp_up),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pc_load     (pc_load),
        .pc_out      (pc_out),
        .acc_load    (acc_load),
        .acc_out     (acc_out),
        .status_load (status_load),
        .status_out  (status_out)
    );

    // R2
    reset_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && op_q == OP_BOOT) |-> $past(mem_rd) && $past(mem_addr) == RESET_VEC + 16'd1);

    // R11
    setsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |=> (sp_out == $past(sp_in)) && !status_load && !acc_load && !pc_load);

endmodule

// File: tb/sim_stk_seq.sv
module sim_stk_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [15:0] pc_in = 16'h0;
    logic [15:0] target_in = 16'h0;
    logic [7:0]  acc_in = 8'h0;
    logic [7:0]  status_in = 8'h0;
    logic [7:0]  sp_in = 8'h0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, busy, done;
    logic        pc_load, acc_load, status_load;
    logic [15:0] pc_out;
    logic [7:0]  acc_out, status_out, sp_out;

    logic [7:0] stk [256];
    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int stray_wr = 0;

    logic        c_pc_load, c_acc_load, c_st_load;
    logic [15:0] c_pc;
    logic [7:0]  c_acc, c_st;
    int          c_cyc;

    always #5 clk = ~clk;

    stk_seq #(.SP_INIT(8'h01)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
        .target_in(target_in), .acc_in(acc_in), .status_in(status_in),
        .sp_in(sp_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy),
        .done(done), .pc_load(pc_load), .pc_out(pc_out), .acc_load(acc_load),
        .acc_out(acc_out), .status_load(status_load), .status_out(status_out),
        .sp_out(sp_out)
    );

    always_comb begin
        if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else if (mem_addr == 16'hFFFC) mem_rdata = 8'h34;
        else if (mem_addr == 16'hFFFD) mem_rdata = 8'h12;
        else if (mem_addr == 16'hFFFE) mem_rdata = 8'h78;
        else if (mem_addr == 16'hFFFF) mem_rdata = 8'h56;
        else mem_rdata = 8'h00;
    end

    always @(posedge clk) begin
        if (mem_wr) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
            else stray_wr <= stray_wr + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        c_cyc = 1;
        while (!done && c_cyc < 40) begin
            @(negedge clk);
            c_cyc++;
        end
        c_pc_load = pc_load; c_pc = pc_out;
        c_acc_load = acc_load; c_acc = acc_out;
        c_st_load = status_load; c_st = status_out;
        @(negedge clk);
    endtask

    task automatic run_op(input logic [3:0] code);
        op = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        chk("R2 sp during reset", sp_out, 8'h01);
        chk("R2 done during reset", done, 0);
        chk("R2 no write in reset", mem_wr, 0);
        rst_n = 1'b1;
        wait_done();
        chk("R2 pc_load", c_pc_load, 1);
        chk("R2 reset vector", c_pc, 16'h1234);
        chk("R13 reset cycles", c_cyc, 3);
    endtask

    task automatic t_push();
        int w0;
        w0 = wr_cnt;
        acc_in = 8'hA5;
        run_op(4'd0);
        chk("R3 push acc data", stk[8'h01], 8'hA5);
        chk("R3 sp after push", sp_out, 8'h00);
        chk("R13 push cycles", c_cyc, 2);
        status_in = 8'h4C;
        run_op(4'd1);
        chk("R5 status forced bits", stk[8'h00], 8'h7C);
        chk("R12 push wraps sp", sp_out, 8'hFF);
        chk("R3 one write per push", wr_cnt - w0, 2);
    endtask

    task automatic t_pull();
        run_op(4'd3);
        chk("R4 sp after pull", sp_out, 8'h00);
        chk("R10 pull status value", c_st, 8'h7C);
        chk("R10 pull status strobes", {c_st_load, c_acc_load}, 2'b10);
        status_in = 8'h03;
        run_op(4'd2);
        chk("R10 pull acc value", c_acc, 8'hA5);
        chk("R10 negative flags", c_st, 8'h81);
        chk("R4 sp after acc pull", sp_out, 8'h01);
        acc_in = 8'h00;
        run_op(4'd0);
        status_in = 8'h80;
        run_op(4'd2);
        chk("R10 zero flags", c_st, 8'h02);
        chk("R10 zero acc", {c_acc_load, c_acc}, 9'h100);
    endtask

    task automatic t_wrap_pull();
        sp_in = 8'hFF;
        run_op(4'd8);
        status_in = 8'h00;
        run_op(4'd2);
        chk("R12 pull at FF reads offset 0", c_acc, 8'h7C);
        chk("R12 sp after wrap pull", sp_out, 8'h00);
    endtask

    task automatic t_setsp();
        int w0;
        w0 = wr_cnt;
        sp_in = 8'h80;
        run_op(4'd8);
        chk("R11 sp written", sp_out, 8'h80);
        chk("R11 no loads", {c_st_load, c_acc_load, c_pc_load}, 3'b000);
        chk("R13 setsp cycles", c_cyc, 1);
        run_op(4'd11);
        chk("R1 undefined code no effect", {c_st_load, c_acc_load, c_pc_load, sp_out}, 11'h080);
        chk("R1 undefined code no access", wr_cnt - w0, 0);
    endtask

    task automatic t_call_ret();
        pc_in = 16'h2003;
        target_in = 16'h4000;
        run_op(4'd4);
        chk("R6 high byte first", stk[8'h80], 8'h20);
        chk("R6 low byte of pc-1", stk[8'h7F], 8'h02);
        chk("R6 target loaded", {c_pc_load, c_pc}, 17'h14000);
        chk("R6 sp", sp_out, 8'h7E);
        chk("R13 call cycles", c_cyc, 3);
        run_op(4'd5);
        chk("R7 return plus one", {c_pc_load, c_pc}, 17'h12003);
        chk("R7 sp", sp_out, 8'h80);
    endtask

    task automatic t_brk_rti();
        pc_in = 16'h3000;
        status_in = 8'h00;
        run_op(4'd7);
        chk("R8 pushed high", stk[8'h80], 8'h30);
        chk("R8 pushed low", stk[8'h7F], 8'h01);
        chk("R8 pushed status", stk[8'h7E], 8'h30);
        chk("R8 vector", c_pc, 16'h5678);
        chk("R8 interrupt disable", {c_st_load, c_st}, 9'h104);
        chk("R8 sp", sp_out, 8'h7D);
        chk("R13 break cycles", c_cyc, 6);
        status_in = 8'hFF;
        run_op(4'd6);
        chk("R9 status restored", {c_st_load, c_st}, 9'h130);
        chk("R9 pc not adjusted", {c_pc_load, c_pc}, 17'h13001);
        chk("R9 sp", sp_out, 8'h80);
        chk("R13 rti cycles", c_cyc, 4);
    endtask

    task automatic t_busy();
        int w0;
        w0 = wr_cnt;
        pc_in = 16'h1235;
        target_in = 16'h0777;
        acc_in = 8'hEE;
        op = 4'd4;
        start = 1'b1;
        @(negedge clk);
        op = 4'd0;
        @(negedge clk);
        start = 1'b0;
        c_cyc = 2;
        while (!done && c_cyc < 40) begin
            @(negedge clk);
            c_cyc++;
        end
        chk("R1 call finished", pc_out, 16'h0777);
        @(negedge clk);
        repeat (3) begin
            chk("R1 no second done", done, 0);
            @(negedge clk);
        end
        chk("R1 sp unaffected", sp_out, 8'h7E);
        chk("R1 writes only from call", wr_cnt - w0, 2);
        chk("R6 busy call low byte", stk[8'h7F], 8'h34);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        t_push();
        t_pull();
        t_wrap_pull();
        t_setsp();
        t_call_ret();
        t_brk_rti();
        t_busy();
        chk("R12 no write outside page", stray_wr, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule